// File: doc/BRIEF.md
# Interrupt Poll and Arbitration Unit

This unit sits beside the instruction sequencer of a small 8-bit processor core. In the final cycle of every instruction it polls three sources: a level-sensitive maskable interrupt line, an edge-triggered non-maskable request and a reset request. It then decides whether the core fetches the next opcode or enters an interrupt entry sequence. The decision comes out one cycle later as a single-cycle take strobe, together with the chosen kind and its vector address. Kind and vector hold until the next poll.

The maskable line is gated by the interrupt-disable flag. The flag value used is the one seen before the finishing instruction writes it, and a parameter selects between two timing variants. On the older variant, a clear of the flag only takes effect one instruction late. A set that immediately follows such a clear still closes the window. On the newer variant, a clear opens the window at once. On the older variant, a non-maskable request that arrives early in a software-break instruction redirects that instruction's vector fetch.

Top module: `int_poll_arb`

## Requirements
- R1: The maskable line `irq_i` (active high, level) produces kind 2'b01 with vector 16'hFFFE only if it is high in the poll cycle and the disable flag in force permits it. With `irq_i` low, or with the flag set and no clearing instruction finishing, no maskable entry occurs.
- R2: A falling edge on `nmi_n_i` is held until accepted and ignores the disable flag. It is accepted at the next poll as kind 2'b10 with vector 16'hFFFA, including an edge seen in the poll cycle itself. Each edge yields only one entry.
- R3: `rst_req_i` is held until accepted and ignores the flag. Priority is reset (kind 2'b11, vector 16'hFFFC) over non-maskable over maskable. Accepting reset discards a pending non-maskable request.
- R4: The decision is sampled when `last_cycle_i` is high. `take_o` pulses high for exactly the next cycle. `kind_o` and `vector_o` change only after a poll and read 2'b00 and 0 when nothing is taken. After reset all outputs are idle and `brk_vector_o` is 16'hFFFE.
- R5: Older variant: when a clear-flag instruction or a pull-status instruction clears the flag while the line is high, one further instruction completes before the maskable entry.
- R6: Older variant: if such a clearing instruction is followed directly by a set-flag instruction, the pending maskable request is not taken at either boundary.
- R7: Older variant: two clearing instructions back to back act as one. The entry follows the second.
- R8: Newer variant: a clear-flag instruction, or a pull-status that loads 0 (`plp_iflag_i`), lets a high line be taken at that same boundary. A pull-status that loads 1 does not.
- R9: Both variants: a set-flag instruction that finishes with the flag clear and the line high is followed immediately by the maskable entry.
- R10: Older variant: a non-maskable edge while `brk_active_i` is high and `brk_cyc_i` is 0 to 4 switches `brk_vector_o` to 16'hFFFA from the next cycle until the break ends, and consumes the request. An edge in cycle 5 or later leaves the vector alone, and the request is taken at the next poll.
- R11: Newer variant: `brk_vector_o` is always 16'hFFFE, and a non-maskable edge during a break stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 1 | Maskable interrupt line, level, active high |
| nmi_n_i | input | 1 | Non-maskable request, falling-edge triggered |
| rst_req_i | input | 1 | Reset request pulse |
| iflag_i | input | 1 | Interrupt-disable flag as currently held (pre-write) |
| last_cycle_i | input | 1 | Final cycle of the current instruction; poll strobe |
| op_cli_i | input | 1 | Finishing instruction clears the flag |
| op_sei_i | input | 1 | Finishing instruction sets the flag |
| op_plp_i | input | 1 | Finishing instruction pulls status from stack |
| plp_iflag_i | input | 1 | Flag value the pull-status instruction loads |
| brk_active_i | input | 1 | Break instruction in progress |
| brk_cyc_i | input | CYC_W | Cycle index within the break instruction |
| take_o | output | 1 | One-cycle strobe: enter interrupt sequence |
| kind_o | output | 2 | Selected kind: 00 none, 01 maskable, 10 non-maskable, 11 reset |
| vector_o | output | ADDR_W | Vector address of the selected kind |
| brk_vector_o | output | ADDR_W | Vector address the break instruction must load |

## Verification
Two collisions matter most. The first is a non-maskable edge that lands in the same cycle as a poll, or in the same cycle as a break-window check. The request then has to be both recognised and consumed on that one edge, never counted twice and never dropped. The second is a reset request that meets a non-maskable edge and an enabled maskable line at one poll. The bench provokes these with directed sequences and with a long seeded random run that toggles every input. It judges each cycle's strobe, kind, vector and break vector for both timing variants against a bench model derived from the requirements.

// File: rtl/int_poll_arb_pkg.sv
package int_poll_arb_pkg;
  typedef enum logic [1:0] {
    KIND_NONE = 2'b00,
    KIND_IRQ  = 2'b01,
    KIND_NMI  = 2'b10,
    KIND_RST  = 2'b11
  } int_kind_e;
endpackage

// File: rtl/nmi_edge_latch.sv
module nmi_edge_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic nmi_n_i,
  input  logic clr_i,
  output logic req_o
);
  logic prev_q, pend_q;

  // an edge seen this cycle already counts as a request
  assign req_o = pend_q | (prev_q & ~nmi_n_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b1;
      pend_q <= 1'b0;
    end else begin
      prev_q <= nmi_n_i;
      pend_q <= req_o & ~clr_i;
    end
  end
endmodule

// File: rtl/irq_gate.sv
module irq_gate #(
  parameter bit OLD_TIMING = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic poll_i,
  input  logic irq_i,
  input  logic iflag_i,
  input  logic cli_i,
  input  logic sei_i,
  input  logic plp_i,
  input  logic plp_iflag_i,
  output logic irq_ok_o
);
  if (OLD_TIMING) begin : g_old
    logic lag_q;  // previous instruction cleared the flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     lag_q <= 1'b0;
      else if (poll_i) lag_q <= iflag_i & (cli_i | (plp_i & ~plp_iflag_i));
    end
    assign irq_ok_o = irq_i & ~iflag_i & ~(sei_i & lag_q);
  end else begin : g_new
    logic eff_flag;
    always_comb begin
      if (cli_i)      eff_flag = 1'b0;
      else if (plp_i) eff_flag = plp_iflag_i;
      else            eff_flag = iflag_i;
    end
    assign irq_ok_o = irq_i & ~eff_flag;
  end
endmodule

// File: rtl/brk_nmi_redirect.sv
module brk_nmi_redirect #(
  parameter bit OLD_TIMING = 1'b1,
  parameter int CYC_W      = 3,
  parameter int BRK_WIN    = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             brk_active_i,
  input  logic [CYC_W-1:0] brk_cyc_i,
  input  logic             nmi_req_i,
  output logic             consume_o,
  output logic             redirect_o
);
  localparam logic [CYC_W-1:0] WinLim = CYC_W'(BRK_WIN);

  if (OLD_TIMING) begin : g_old
    logic hit_q;
    logic in_win;
    assign in_win    = brk_active_i && (brk_cyc_i < WinLim);
    assign consume_o = in_win & nmi_req_i & ~hit_q;
    assign redirect_o = hit_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           hit_q <= 1'b0;
      else if (brk_active_i) hit_q <= hit_q | consume_o;
      else                   hit_q <= 1'b0;
    end
  end else begin : g_new
    assign consume_o  = 1'b0;
    assign redirect_o = 1'b0;
  end
endmodule

// File: rtl/int_poll_arb.sv
module int_poll_arb
  import int_poll_arb_pkg::*;
#(
  parameter bit              OLD_TIMING = 1'b1,
  parameter int              ADDR_W     = 16,
  parameter int              CYC_W      = 3,
  parameter int              BRK_WIN    = 5,
  parameter logic [ADDR_W-1:0] VEC_NMI  = ADDR_W'('hFFFA),
  parameter logic [ADDR_W-1:0] VEC_RST  = ADDR_W'('hFFFC),
  parameter logic [ADDR_W-1:0] VEC_IRQ  = ADDR_W'('hFFFE)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              irq_i,
  input  logic              nmi_n_i,
  input  logic              rst_req_i,
  input  logic              iflag_i,
  input  logic              last_cycle_i,
  input  logic              op_cli_i,
  input  logic              op_sei_i,
  input  logic              op_plp_i,
  input  logic              plp_iflag_i,
  input  logic              brk_active_i,
  input  logic [CYC_W-1:0]  brk_cyc_i,
  output logic              take_o,
  output logic [1:0]        kind_o,
  output logic [ADDR_W-1:0] vector_o,
  output logic [ADDR_W-1:0] brk_vector_o
);
  logic      nmi_req, nmi_clr, brk_consume, brk_redirect, irq_ok;
  logic      rst_pend_q, rst_req, take_q;
  int_kind_e pick, kind_q;

  nmi_edge_latch u_nmi (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .nmi_n_i (nmi_n_i),
    .clr_i   (nmi_clr),
    .req_o   (nmi_req)
  );

  irq_gate #(.OLD_TIMING(OLD_TIMING)) u_gate (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .poll_i      (last_cycle_i),
    .irq_i       (irq_i),
    .iflag_i     (iflag_i),
    .cli_i       (op_cli_i),
    .sei_i       (op_sei_i),
    .plp_i       (op_plp_i),
    .plp_iflag_i (plp_iflag_i),
    .irq_ok_o    (irq_ok)
  );

  brk_nmi_redirect #(
    .OLD_TIMING (OLD_TIMING),
    .CYC_W      (CYC_W),
    .BRK_WIN    (BRK_WIN)
  ) u_brk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .brk_active_i (brk_active_i),
    .brk_cyc_i    (brk_cyc_i),
    .nmi_req_i    (nmi_req),
    .consume_o    (brk_consume),
    .redirect_o   (brk_redirect)
  );

  assign rst_req = rst_pend_q | rst_req_i;

  always_comb begin
    if (rst_req)                     pick = KIND_RST;
    else if (nmi_req & ~brk_consume) pick = KIND_NMI;
    else if (irq_ok)                 pick = KIND_IRQ;
    else                             pick = KIND_NONE;
  end

  // reset acceptance also drops a pending NMI
  assign nmi_clr = brk_consume |
                   (last_cycle_i & ((pick == KIND_NMI) | (pick == KIND_RST)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_pend_q <= 1'b0;
      take_q     <= 1'b0;
      kind_q     <= KIND_NONE;
    end else begin
      rst_pend_q <= rst_req & ~(last_cycle_i & (pick == KIND_RST));
      take_q     <= last_cycle_i & (pick != KIND_NONE);
      if (last_cycle_i) kind_q <= pick;
    end
  end

  always_comb begin
    unique case (kind_q)
      KIND_RST: vector_o = VEC_RST;
      KIND_NMI: vector_o = VEC_NMI;
      KIND_IRQ: vector_o = VEC_IRQ;
      default:  vector_o = '0;
    endcase
  end

  assign take_o       = take_q;
  assign kind_o       = kind_q;
  assign brk_vector_o = brk_redirect ? VEC_NMI : VEC_IRQ;
endmodule

// File: rtl/int_poll_arb_chk.sv
module int_poll_arb_chk #(
  parameter bit              OLD_TIMING = 1'b1,
  parameter int              ADDR_W     = 16,
  parameter int              CYC_W      = 3,
  parameter logic [ADDR_W-1:0] VEC_NMI  = ADDR_W'('hFFFA),
  parameter logic [ADDR_W-1:0] VEC_IRQ  = ADDR_W'('hFFFE)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              irq_i,
  input logic              nmi_n_i,
  input logic              rst_req_i,
  input logic              iflag_i,
  input logic              last_cycle_i,
  input logic              op_cli_i,
  input logic              op_sei_i,
  input logic              op_plp_i,
  input logic              plp_iflag_i,
  input logic              brk_active_i,
  input logic [CYC_W-1:0]  brk_cyc_i,
  input logic              take_o,
  input logic [1:0]        kind_o,
  input logic [ADDR_W-1:0] vector_o,
  input logic [ADDR_W-1:0] brk_vector_o
);
  assert_take_kind_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> kind_o != 2'b00);

  assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !last_cycle_i |=> (!take_o && $stable(kind_o) && $stable(vector_o)));

  assert_reset_first_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_cycle_i && rst_req_i) |=> (take_o && kind_o == 2'b11));

  assert_irq_needs_line_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_cycle_i && !irq_i) |=> kind_o != 2'b01);

  assert_nmi_vector_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && kind_o == 2'b10) |-> vector_o == VEC_NMI);

  assert_brk_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !brk_active_i |=> brk_vector_o == VEC_IRQ);

  if (!OLD_TIMING) begin : g_new
    assert_no_redirect_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      brk_vector_o == VEC_IRQ);
  end
endmodule

bind int_poll_arb int_poll_arb_chk #(
  .OLD_TIMING (OLD_TIMING),
  .ADDR_W     (ADDR_W),
  .CYC_W      (CYC_W),
  .VEC_NMI    (VEC_NMI),
  .VEC_IRQ    (VEC_IRQ)
) u_chk (.*);

// File: tb/sim_int_poll_arb.sv
module sim_int_poll_arb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic irq = 0, nmi_n = 1, rst_req = 0, iflag = 1, last = 0;
  logic cli = 0, sei = 0, plp = 0, plpv = 0, bact = 0;
  logic [2:0] bcyc = '0;
  logic t0, t1;
  logic [1:0] k0, k1;
  logic [15:0] v0, v1, b0, b1;

  int checks = 0, errors = 0;
  bit done = 0;
  string tag = "R4";

  always #4 clk = ~clk;

  int_poll_arb #(.OLD_TIMING(1'b1)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .nmi_n_i(nmi_n), .rst_req_i(rst_req),
    .iflag_i(iflag), .last_cycle_i(last), .op_cli_i(cli), .op_sei_i(sei),
    .op_plp_i(plp), .plp_iflag_i(plpv), .brk_active_i(bact), .brk_cyc_i(bcyc),
    .take_o(t0), .kind_o(k0), .vector_o(v0), .brk_vector_o(b0));

  int_poll_arb #(.OLD_TIMING(1'b0)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .nmi_n_i(nmi_n), .rst_req_i(rst_req),
    .iflag_i(iflag), .last_cycle_i(last), .op_cli_i(cli), .op_sei_i(sei),
    .op_plp_i(plp), .plp_iflag_i(plpv), .brk_active_i(bact), .brk_cyc_i(bcyc),
    .take_o(t1), .kind_o(k1), .vector_o(v1), .brk_vector_o(b1));

  // bench model, index 0 = older variant, 1 = newer variant
  bit m_prev[2] = '{1, 1};
  bit m_np[2], m_rp[2], m_lag[2], m_hit[2], m_take[2];
  logic [1:0] m_kind[2] = '{2'b00, 2'b00};

  function automatic logic [15:0] vec_of(logic [1:0] k);
    case (k)
      2'b11:   return 16'hFFFC;
      2'b10:   return 16'hFFFA;
      2'b01:   return 16'hFFFE;
      default: return 16'h0000;
    endcase
  endfunction

  task automatic chk(string t, logic [47:0] got, logic [47:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", t, got, exp);
    end
  endtask

  task automatic model_step();
    for (int v = 0; v < 2; v++) begin
      bit old = (v == 0);
      bit fall = m_prev[v] & ~nmi_n;
      bit nreq = m_np[v] | fall;
      bit rreq = m_rp[v] | rst_req;
      bit win = old && bact && (bcyc < 3'd5);
      bit bcons = win & nreq & ~m_hit[v];
      bit eff = old ? iflag : (cli ? 1'b0 : (plp ? plpv : iflag));
      bit irqok = irq & ~eff & ~(old & sei & m_lag[v]);
      logic [1:0] pk = rreq ? 2'b11 : ((nreq & ~bcons) ? 2'b10 : (irqok ? 2'b01 : 2'b00));
      m_take[v] = last && (pk != 2'b00);
      if (last) begin
        m_kind[v] = pk;
        m_lag[v] = iflag & (cli | (plp & ~plpv));
      end
      m_rp[v] = rreq & ~(last && pk == 2'b11);
      m_np[v] = nreq & ~(bcons | (last && pk[1]));
      m_hit[v] = bact ? (m_hit[v] | bcons) : 1'b0;
      m_prev[v] = nmi_n;
    end
  endtask

  task automatic tick();
    model_step();
    @(posedge clk);
    @(negedge clk);
    chk({tag, " model u0"}, {15'd0, t0, 14'd0, k0, v0},
        {15'd0, m_take[0], 14'd0, m_kind[0], vec_of(m_kind[0])});
    chk({tag, " model u1"}, {15'd0, t1, 14'd0, k1, v1},
        {15'd0, m_take[1], 14'd0, m_kind[1], vec_of(m_kind[1])});
    chk({tag, " brkvec u0"}, {32'd0, b0}, {32'd0, m_hit[0] ? 16'hFFFA : 16'hFFFE});
    chk({tag, " brkvec u1"}, {32'd0, b1}, {32'd0, m_hit[1] ? 16'hFFFA : 16'hFFFE});
  endtask

  // op: 0 nop, 1 cli, 2 sei, 3 plp
  task automatic instr(int op, bit pv);
    cli = (op == 1); sei = (op == 2); plp = (op == 3); plpv = pv; last = 1;
    tick();
    cli = 0; sei = 0; plp = 0; plpv = 0; last = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got hang expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R4 reset state
    chk("R4 reset u0", {t0, k0, v0, b0}, {1'b0, 2'b00, 16'h0, 16'hFFFE});
    chk("R4 reset u1", {t1, k1, v1, b1}, {1'b0, 2'b00, 16'h0, 16'hFFFE});

    // R1 masked and idle line
    tag = "R1"; irq = 1; iflag = 1; instr(0, 0);
    chk("R1 masked u0", {47'd0, t0}, 48'd0);
    irq = 0; iflag = 0; instr(0, 0);
    chk("R1 no line u1", {47'd0, t1}, 48'd0);

    // R5 / R8 clear-flag delay
    tag = "R5"; irq = 1; iflag = 1; instr(1, 0);
    chk("R5 cli u0 waits", {47'd0, t0}, 48'd0);
    chk("R8 cli u1 immediate", {46'd0, t1, k1}, {46'd0, 1'b1, 2'b01});
    iflag = 0; instr(0, 0);
    chk("R5 next instr u0", {30'd0, t0, k0, v0}, {30'd0, 1'b1, 2'b01, 16'hFFFE});

    // R6 clear then set
    tag = "R6"; iflag = 1; instr(1, 0);
    iflag = 0; instr(2, 0);
    chk("R6 sei after cli u0", {47'd0, t0}, 48'd0);
    iflag = 1; instr(0, 0);
    chk("R6 stays masked u0", {47'd0, t0}, 48'd0);

    // R7 back-to-back
    tag = "R7"; iflag = 1; instr(1, 0);
    chk("R7 first cli u0", {47'd0, t0}, 48'd0);
    iflag = 0; instr(1, 0);
    chk("R7 second cli u0", {46'd0, t0, k0}, {46'd0, 1'b1, 2'b01});

    // R5 / R8 pull-status
    tag = "R8"; iflag = 1; instr(3, 0);
    chk("R8 plp0 u1", {46'd0, t1, k1}, {46'd0, 1'b1, 2'b01});
    chk("R5 plp0 u0 waits", {47'd0, t0}, 48'd0);
    iflag = 0; instr(0, 0);
    chk("R5 plp next u0", {47'd0, t0}, 48'd1);
    iflag = 1; instr(3, 1);
    chk("R8 plp1 u1", {47'd0, t1}, 48'd0);

    // R9 set-flag interruptible
    tag = "R9"; irq = 0; iflag = 0; instr(0, 0);
    irq = 1; instr(2, 0);
    chk("R9 sei u0", {46'd0, t0, k0}, {46'd0, 1'b1, 2'b01});
    chk("R9 sei u1", {46'd0, t1, k1}, {46'd0, 1'b1, 2'b01});

    // R2 NMI ignores flag, one entry per edge, edge in poll cycle
    tag = "R2"; irq = 0; iflag = 1; nmi_n = 0; instr(0, 0);
    chk("R2 nmi u0", {29'd0, t0, k0, v0}, {29'd0, 1'b1, 2'b10, 16'hFFFA});
    instr(0, 0);
    chk("R2 single take u1", {47'd0, t1}, 48'd0);
    // R4 hold after poll
    tag = "R4"; tick();
    chk("R4 hold u0", {46'd0, t0, k0}, {46'd0, 1'b0, 2'b00});
    nmi_n = 1; tick();

    // R3 priority
    tag = "R3"; irq = 1; iflag = 0; rst_req = 1; nmi_n = 0; instr(0, 0);
    rst_req = 0;
    chk("R3 reset wins u0", {29'd0, t0, k0, v0}, {29'd0, 1'b1, 2'b11, 16'hFFFC});
    instr(0, 0);
    chk("R3 nmi dropped u1", {46'd0, t1, k1}, {46'd0, 1'b1, 2'b01});
    nmi_n = 1; irq = 0; iflag = 1; tick();

    // R10 / R11 early NMI during break
    tag = "R10"; bact = 1;
    for (int c = 0; c < 7; c++) begin
      bcyc = 3'(c); nmi_n = (c >= 2) ? 1'b0 : 1'b1; last = (c == 6);
      tick();
      if (c == 3) begin
        chk("R10 redirect u0", {32'd0, b0}, {32'd0, 16'hFFFA});
        chk("R11 no redirect u1", {32'd0, b1}, {32'd0, 16'hFFFE});
      end
    end
    chk("R10 consumed u0", {47'd0, t0}, 48'd0);
    chk("R11 pending u1", {46'd0, t1, k1}, {46'd0, 1'b1, 2'b10});
    last = 0; bact = 0; bcyc = 0; nmi_n = 1; tick();
    chk("R10 cleared u0", {32'd0, b0}, {32'd0, 16'hFFFE});

    // R10 late NMI
    bact = 1;
    for (int c = 0; c < 7; c++) begin
      bcyc = 3'(c); nmi_n = (c >= 5) ? 1'b0 : 1'b1; last = (c == 6);
      tick();
    end
    chk("R10 late vec u0", {32'd0, b0}, {32'd0, 16'hFFFE});
    chk("R10 late taken u0", {46'd0, t0, k0}, {46'd0, 1'b1, 2'b10});
    last = 0; bact = 0; bcyc = 0; nmi_n = 1; tick();

    // random run against the model
    tag = "R4 random";
    for (int i = 0; i < 3000; i++) begin
      int op = $urandom_range(0, 3);
      irq = $urandom_range(0, 1);
      if ($urandom_range(0, 7) == 0) nmi_n = ~nmi_n;
      rst_req = ($urandom_range(0, 63) == 0);
      iflag = $urandom_range(0, 1);
      last = ($urandom_range(0, 2) == 0);
      cli = (op == 1); sei = (op == 2); plp = (op == 3);
      plpv = $urandom_range(0, 1);
      bact = $urandom_range(0, 1);
      bcyc = 3'($urandom_range(0, 7));
      tick();
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule